// File: doc/BRIEF.md
# RTC Interrupt Emulation Engine

This block rebuilds the three interrupt causes of a legacy real-time clock (once-a-second update, time-of-day alarm, programmable periodic rate) from a single timer tick. An external comparator channel produces the tick. The tick normally arrives at 64 Hz, a rate chosen as a compromise between event accuracy and interrupt load. Update and alarm events are found by polling the current hours, minutes and seconds from a time-of-day source on every tick. Periodic events come from dividing the tick, or from running the tick itself faster when the requested rate is above 64 Hz.

The tick can be serviced late, so the comparator may have to be advanced more than once to get ahead of the counter. The comparator reports those extra advances with each tick. The engine accumulates them in a saturating lost-tick counter and folds them into the periodic divider. The engine also tells the comparator side whether the tick channel should run at all and which log2 rate it should run at. Its flags are sticky until software acknowledges them. A single interrupt request combines those flags that are enabled.

Top module: `rtc_emu_engine`

## Requirements
- R1: After a synchronous reset, all flags, irq_o, chan_en_o and lost_cnt_o are 0, and tick_rate_o is 6 (the 64 Hz base rate).
- R2: chan_en_o equals the OR of en_upd_i, en_alm_i and en_per_i, one clock later. When all three are clear the tick channel is off.
- R3: On a tick with en_upd_i set, flag_upd_o is raised if sec_i differs from the last recorded update second, and the recorded second then takes sec_i. After reset the recorded second is 63, so the first enabled tick always fires. A tick with en_upd_i clear leaves the recorded second unchanged.
- R4: On a tick with en_alm_i set, flag_alm_o is raised only when hour_i, min_i and sec_i all equal alm_hour_i, alm_min_i and alm_sec_i.
- R5: rate_code_i holds log2 of the periodic rate in Hz. For codes 1 to 6, flag_per_o is raised once every 2^(6-code) ticks. The divider count starts from 0 and clears when it fires, and it is held at 0 while en_per_i is clear.
- R6: For codes 7 to 13 with en_per_i set, tick_rate_o equals the code and every tick raises flag_per_o. In every other case tick_rate_o is 6.
- R7: Codes 0, 14 and 15 disable the periodic source: no periodic flag is raised and the divider stays at 0.
- R8: Each tick adds miss_i to lost_cnt_o, which saturates at its all-ones value. While the periodic source is active, miss_i is also added to the divider count before that tick's increment.
- R9: Flags stay set until an ack_i cycle clears them. An event in the same cycle as ack_i wins, and its flag stays set.
- R10: flag_any_o is set whenever any of the three flags is raised, and it is cleared only by ack_i.
- R11: irq_o is registered and equals the OR of each flag ANDed with its enable, both taken after the same clock edge. flag_any_o does not drive irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle tick from the comparator channel |
| miss_i | input | MISS_W | Extra comparator advances reported with this tick |
| hour_i | input | TW | Current hours |
| min_i | input | TW | Current minutes |
| sec_i | input | TW | Current seconds |
| en_upd_i | input | 1 | Update event enable |
| en_alm_i | input | 1 | Alarm event enable |
| en_per_i | input | 1 | Periodic event enable |
| alm_hour_i | input | TW | Alarm hours |
| alm_min_i | input | TW | Alarm minutes |
| alm_sec_i | input | TW | Alarm seconds |
| rate_code_i | input | CODE_W | log2 of the periodic rate |
| ack_i | input | 1 | Clears all flags |
| flag_upd_o | output | 1 | Sticky update flag |
| flag_alm_o | output | 1 | Sticky alarm flag |
| flag_per_o | output | 1 | Sticky periodic flag |
| flag_any_o | output | 1 | Sticky summary flag |
| irq_o | output | 1 | Combined interrupt request |
| chan_en_o | output | 1 | Tick channel enable |
| tick_rate_o | output | CODE_W | Requested log2 tick rate |
| lost_cnt_o | output | LOST_W | Saturating lost-tick count |

## Verification
The hardest case to reach is a late tick landing on a periodic divider that is part-way through its count. The extra advances must then push the count across the limit one tick early. The bench reaches it by enabling a slow rate from a cleared divider, sending a single plain tick, and then sending a tick that carries a miss count sized to hit the limit exactly. This comes after a full sweep of all sixteen rate codes, each from a known zero count. Lost-counter saturation is reached by building the bench with a narrow counter and repeating large miss values.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
  typedef struct packed {
    logic per;
    logic alm;
    logic upd;
  } rtc_evt_t;

  localparam int unsigned NUM_SRC = 3;
endpackage

// File: rtl/rtc_emu_rate_dec.sv
module rtc_emu_rate_dec #(
  parameter int BASE_LOG2 = 6,
  parameter int MAX_LOG2  = 13,
  parameter int CODE_W    = 4,
  parameter int LIM_W     = BASE_LOG2 + 1
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              valid_o,
  output logic              fast_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic [CODE_W-1:0] rate_o
);
  int sh;

  always_comb begin
    valid_o = (int'(code_i) >= 1) && (int'(code_i) <= MAX_LOG2);
    fast_o  = valid_o && (int'(code_i) > BASE_LOG2);
    sh      = BASE_LOG2 - int'(code_i);
    limit_o = '0;
    if (fast_o)
      limit_o = LIM_W'(1);
    else if (valid_o)
      limit_o = LIM_W'(1 << sh);
    rate_o = fast_o ? code_i : CODE_W'(BASE_LOG2);
  end
endmodule

// File: rtl/rtc_emu_per_div.sv
module rtc_emu_per_div #(
  parameter int LIM_W  = 7,
  parameter int MISS_W = 4,
  parameter int SUM_W  = ((LIM_W > MISS_W) ? LIM_W : MISS_W) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              active_i,
  input  logic [LIM_W-1:0]  limit_i,
  input  logic [MISS_W-1:0] miss_i,
  output logic              fire_o
);
  logic [LIM_W-1:0] cnt_q;
  logic [SUM_W-1:0] sum;

  always_comb begin
    sum    = SUM_W'(cnt_q) + SUM_W'(miss_i) + SUM_W'(1);
    fire_o = tick_i && active_i && (sum >= SUM_W'(limit_i));
  end

  always_ff @(posedge clk) begin
    if (rst || !active_i)
      cnt_q <= '0;
    else if (tick_i)
      cnt_q <= fire_o ? '0 : LIM_W'(sum);
  end
endmodule

// File: rtl/rtc_emu_tod_events.sv
module rtc_emu_tod_events #(
  parameter int TW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          en_upd_i,
  input  logic          en_alm_i,
  input  logic [TW-1:0] hour_i,
  input  logic [TW-1:0] min_i,
  input  logic [TW-1:0] sec_i,
  input  logic [TW-1:0] alm_hour_i,
  input  logic [TW-1:0] alm_min_i,
  input  logic [TW-1:0] alm_sec_i,
  output logic          upd_hit_o,
  output logic          alm_hit_o
);
  logic [TW-1:0] last_sec_q;

  always_comb begin
    upd_hit_o = tick_i && en_upd_i && (sec_i != last_sec_q);
    alm_hit_o = tick_i && en_alm_i && (hour_i == alm_hour_i) &&
                (min_i == alm_min_i) && (sec_i == alm_sec_i);
  end

  always_ff @(posedge clk) begin
    if (rst)
      last_sec_q <= '1;
    else if (upd_hit_o)
      last_sec_q <= sec_i;
  end
endmodule

// File: rtl/rtc_emu_engine.sv
module rtc_emu_engine
  import rtc_emu_pkg::*;
#(
  parameter int TW        = 6,
  parameter int MISS_W    = 4,
  parameter int LOST_W    = 16,
  parameter int CODE_W    = 4,
  parameter int BASE_LOG2 = 6,
  parameter int MAX_LOG2  = 13
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic [MISS_W-1:0] miss_i,
  input  logic [TW-1:0]     hour_i,
  input  logic [TW-1:0]     min_i,
  input  logic [TW-1:0]     sec_i,
  input  logic              en_upd_i,
  input  logic              en_alm_i,
  input  logic              en_per_i,
  input  logic [TW-1:0]     alm_hour_i,
  input  logic [TW-1:0]     alm_min_i,
  input  logic [TW-1:0]     alm_sec_i,
  input  logic [CODE_W-1:0] rate_code_i,
  input  logic              ack_i,
  output logic              flag_upd_o,
  output logic              flag_alm_o,
  output logic              flag_per_o,
  output logic              flag_any_o,
  output logic              irq_o,
  output logic              chan_en_o,
  output logic [CODE_W-1:0] tick_rate_o,
  output logic [LOST_W-1:0] lost_cnt_o
);
  localparam int LIM_W = BASE_LOG2 + 1;

  logic              rate_valid, rate_fast;
  logic [LIM_W-1:0]  rate_limit;
  logic [CODE_W-1:0] rate_dec;
  logic              per_active;
  rtc_evt_t          hit, flags_q, flags_nxt, en_vec;
  logic              any_q, any_nxt;
  logic [LOST_W:0]   lost_sum;

  rtc_emu_rate_dec #(
    .BASE_LOG2(BASE_LOG2), .MAX_LOG2(MAX_LOG2), .CODE_W(CODE_W), .LIM_W(LIM_W)
  ) rate_i (
    .code_i(rate_code_i), .valid_o(rate_valid), .fast_o(rate_fast),
    .limit_o(rate_limit), .rate_o(rate_dec)
  );

  assign per_active = en_per_i && rate_valid;

  rtc_emu_per_div #(.LIM_W(LIM_W), .MISS_W(MISS_W)) div_i (
    .clk(clk), .rst(rst), .tick_i(tick_i), .active_i(per_active),
    .limit_i(rate_limit), .miss_i(miss_i), .fire_o(hit.per)
  );

  rtc_emu_tod_events #(.TW(TW)) tod_i (
    .clk(clk), .rst(rst), .tick_i(tick_i),
    .en_upd_i(en_upd_i), .en_alm_i(en_alm_i),
    .hour_i(hour_i), .min_i(min_i), .sec_i(sec_i),
    .alm_hour_i(alm_hour_i), .alm_min_i(alm_min_i), .alm_sec_i(alm_sec_i),
    .upd_hit_o(hit.upd), .alm_hit_o(hit.alm)
  );

  always_comb begin
    en_vec.upd = en_upd_i;
    en_vec.alm = en_alm_i;
    en_vec.per = en_per_i;
    flags_nxt  = (ack_i ? rtc_evt_t'('0) : flags_q) | hit;
    any_nxt    = (ack_i ? 1'b0 : any_q) | (|hit);
    lost_sum   = {1'b0, lost_cnt_o} + (LOST_W+1)'(miss_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q     <= '0;
      any_q       <= 1'b0;
      irq_o       <= 1'b0;
      chan_en_o   <= 1'b0;
      tick_rate_o <= CODE_W'(BASE_LOG2);
      lost_cnt_o  <= '0;
    end else begin
      flags_q     <= flags_nxt;
      any_q       <= any_nxt;
      irq_o       <= |(flags_nxt & en_vec);
      chan_en_o   <= en_upd_i | en_alm_i | en_per_i;
      tick_rate_o <= (en_per_i && rate_fast) ? rate_dec : CODE_W'(BASE_LOG2);
      if (tick_i)
        lost_cnt_o <= lost_sum[LOST_W] ? '1 : lost_sum[LOST_W-1:0];
    end
  end

  assign flag_upd_o = flags_q.upd;
  assign flag_alm_o = flags_q.alm;
  assign flag_per_o = flags_q.per;
  assign flag_any_o = any_q;
endmodule

// File: rtl/rtc_emu_engine_chk.sv
module rtc_emu_engine_chk #(
  parameter int CODE_W    = 4,
  parameter int BASE_LOG2 = 6,
  parameter int MAX_LOG2  = 13
) (
  input logic              clk,
  input logic              rst,
  input logic              tick_i,
  input logic              ack_i,
  input logic              en_upd_i,
  input logic              en_alm_i,
  input logic              en_per_i,
  input logic              flag_upd_o,
  input logic              flag_alm_o,
  input logic              flag_per_o,
  input logic              flag_any_o,
  input logic              irq_o,
  input logic              chan_en_o,
  input logic [CODE_W-1:0] tick_rate_o
);
  // R2
  a_r2_chan_follows_enables: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> chan_en_o == $past(en_upd_i || en_alm_i || en_per_i));

  // R9
  a_r9_ack_without_tick_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !tick_i) |=> !flag_upd_o && !flag_alm_o && !flag_per_o && !flag_any_o);

  // R3, R4, R5
  a_r3_flag_rise_needs_tick: assert property (@(posedge clk) disable iff (rst)
    ($rose(flag_upd_o) || $rose(flag_alm_o) || $rose(flag_per_o)) |-> $past(tick_i));

  // R3
  a_r3_update_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_upd_o) |-> $past(en_upd_i));

  // R4
  a_r4_alarm_needs_enable: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_alm_o) |-> $past(en_alm_i));

  // R10
  a_r10_summary_covers_flags: assert property (@(posedge clk) disable iff (rst)
    (flag_upd_o || flag_alm_o || flag_per_o) |-> flag_any_o);

  // R11
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (flag_upd_o || flag_alm_o || flag_per_o));

  // R6
  a_r6_rate_in_range: assert property (@(posedge clk) disable iff (rst)
    (int'(tick_rate_o) >= BASE_LOG2) && (int'(tick_rate_o) <= MAX_LOG2));
endmodule

bind rtc_emu_engine rtc_emu_engine_chk #(
  .CODE_W(CODE_W), .BASE_LOG2(BASE_LOG2), .MAX_LOG2(MAX_LOG2)
) chk_i (
  .clk(clk), .rst(rst), .tick_i(tick_i), .ack_i(ack_i),
  .en_upd_i(en_upd_i), .en_alm_i(en_alm_i), .en_per_i(en_per_i),
  .flag_upd_o(flag_upd_o), .flag_alm_o(flag_alm_o), .flag_per_o(flag_per_o),
  .flag_any_o(flag_any_o), .irq_o(irq_o), .chan_en_o(chan_en_o),
  .tick_rate_o(tick_rate_o)
);

// File: tb/rtc_emu_engine_tb_top.sv
module rtc_emu_engine_tb_top;
  localparam int TW = 6, MISS_W = 4, LOST_W = 5, CODE_W = 4;
  localparam int LOST_MAX = (1 << LOST_W) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic tick = 1'b0, ack = 1'b0;
  logic [MISS_W-1:0] miss = '0;
  logic [TW-1:0] hour = '0, min = '0, sec = '0;
  logic en_upd = 1'b0, en_alm = 1'b0, en_per = 1'b0;
  logic [TW-1:0] a_hour = '0, a_min = '0, a_sec = '0;
  logic [CODE_W-1:0] code = '0;
  logic f_upd, f_alm, f_per, f_any, irq, chan_en;
  logic [CODE_W-1:0] trate;
  logic [LOST_W-1:0] lost;

  int errors = 0, checks = 0, cycles = 0, lost_exp = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rtc_emu_engine #(.TW(TW), .MISS_W(MISS_W), .LOST_W(LOST_W), .CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst(rst), .tick_i(tick), .miss_i(miss),
    .hour_i(hour), .min_i(min), .sec_i(sec),
    .en_upd_i(en_upd), .en_alm_i(en_alm), .en_per_i(en_per),
    .alm_hour_i(a_hour), .alm_min_i(a_min), .alm_sec_i(a_sec),
    .rate_code_i(code), .ack_i(ack),
    .flag_upd_o(f_upd), .flag_alm_o(f_alm), .flag_per_o(f_per), .flag_any_o(f_any),
    .irq_o(irq), .chan_en_o(chan_en), .tick_rate_o(trate), .lost_cnt_o(lost)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=0", cycles);
      summary();
    end
  end

  // one tick; outputs sampled on the following negedge
  task automatic do_tick(int m);
    tick = 1'b1; miss = MISS_W'(m);
    lost_exp = (lost_exp + m > LOST_MAX) ? LOST_MAX : lost_exp + m;
    @(negedge clk);
    tick = 1'b0; miss = '0;
  endtask

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic idle(); @(negedge clk); endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 flags", int'({f_upd, f_alm, f_per, f_any}), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 chan_en", int'(chan_en), 0);
    chk("R1 rate", int'(trate), 6);
    chk("R1 lost", int'(lost), 0);

    // R2 channel enable
    en_alm = 1'b1; idle();
    chk("R2 chan on", int'(chan_en), 1);
    en_alm = 1'b0; idle();
    chk("R2 chan off", int'(chan_en), 0);

    // R3 update: disabled tick records nothing, first enabled tick fires
    sec = 7; do_tick(0);
    chk("R3 disabled no flag", int'(f_upd), 0);
    en_upd = 1'b1; do_tick(0);
    chk("R3 first fires", int'(f_upd), 1);
    chk("R10 summary", int'(f_any), 1);
    chk("R11 irq upd", int'(irq), 1);
    do_ack();
    chk("R9 ack clears", int'({f_upd, f_any, irq}), 0);
    for (int s = 8; s < 68; s++) begin
      sec = TW'(s % 60);
      do_tick(0);
      chk("R3 new second fires", int'(f_upd), 1);
      do_ack();
      do_tick(0);
      chk("R3 same second quiet", int'(f_upd), 0);
    end
    en_upd = 1'b0; idle();

    // R4 alarm
    en_alm = 1'b1; a_hour = 10; a_min = 20; a_sec = 30;
    for (int v = 0; v < 8; v++) begin
      hour = (v & 1) ? 6'd11 : 6'd10;
      min  = (v & 2) ? 6'd21 : 6'd20;
      sec  = (v & 4) ? 6'd31 : 6'd30;
      do_tick(0);
      chk("R4 alarm match", int'(f_alm), (v == 0) ? 1 : 0);
      do_ack();
    end
    // R11 masking: flag stays, irq follows enable
    hour = 10; min = 20; sec = 30;
    do_tick(0);
    chk("R11 irq alm", int'(irq), 1);
    en_alm = 1'b0; idle();
    chk("R11 masked irq", int'(irq), 0);
    chk("R9 flag sticky", int'(f_alm), 1);
    en_alm = 1'b1; idle();
    chk("R11 irq back", int'(irq), 1);
    // R9 event wins over ack in same cycle
    ack = 1'b1; do_tick(0); ack = 1'b0;
    chk("R9 event beats ack", int'(f_alm), 1);
    do_ack();
    en_alm = 1'b0; idle();

    // R5 R6 R7 periodic sweep over every code
    for (int c = 0; c < 16; c++) begin
      int lim;
      bit vld;
      vld = (c >= 1 && c <= 13);
      lim = (c <= 6) ? (1 << (6 - c)) : 1;
      en_per = 1'b0; code = CODE_W'(c); idle(); do_ack();
      en_per = 1'b1; idle();
      chk("R6 tick rate", int'(trate), (vld && c > 6) ? c : 6);
      for (int k = 1; k <= 40; k++) begin
        do_tick(0);
        if (c <= 6 && vld) chk("R5 slow divide", int'(f_per), (k % lim == 0) ? 1 : 0);
        else if (vld)      chk("R6 every tick", int'(f_per), 1);
        else               chk("R7 invalid code", int'(f_per), 0);
        do_ack();
      end
    end

    // R8 lost ticks advance the divider: code 4 -> every 4 ticks
    en_per = 1'b0; code = 4; idle();
    en_per = 1'b1; idle();
    do_tick(0);
    chk("R8 before", int'(f_per), 0);
    do_tick(2);
    chk("R8 miss fires early", int'(f_per), 1);
    do_ack();
    do_tick(0);
    chk("R8 restart", int'(f_per), 0);
    chk("R8 lost count", int'(lost), lost_exp);
    // R5 disable clears count
    do_tick(0); do_tick(0);
    en_per = 1'b0; idle(); en_per = 1'b1; idle(); do_ack();
    do_tick(0);
    chk("R5 cleared by disable", int'(f_per), 0);
    en_per = 1'b0; idle();
    // R8 saturation
    for (int i = 0; i < 4; i++) begin
      do_tick(15);
      chk("R8 lost saturate", int'(lost), lost_exp);
    end
    chk("R8 at max", int'(lost), LOST_MAX);

    summary();
  end
endmodule